// File: doc/BRIEF.md
# Serial Control Bus Register Slave

This block is a two-wire serial bus slave running on a fast system clock. It gives a bus master write access to a bank of eight 8-bit control registers and read access to three status bytes that come from outside the block. Both bus lines pass through two-flop synchronisers before any decision is made. Start and stop conditions are recognised from the synchronised lines. The data line is never driven high: the block only asserts a pull-low enable, and the external pull-up provides the high level.

Writes have an unusual framing. After the device address, every data byte is preceded by its own register-select byte. Such select/data pairs can repeat any number of times before the stop condition ends the transfer. Reads take no register select at all. The slave always opens a read with the first status byte and then walks a fixed cyclic list for as long as the master keeps acknowledging. Bit 7 of control register 0 selects between a three-entry list and a five-entry list.

Top module: `scb_ctrl_slave`

## Requirements
- R1: The slave responds only to the 7-bit device address 06h. The address byte carries the direction in its least significant bit, with 1 meaning read. A byte holding any other address is not acknowledged, and every byte after it is ignored until the next start.
- R2: The slave pulls SDA low during the ninth clock after each byte it receives: the matching address byte, each register-select byte and each data byte.
- R3: Only the three low bits of a register-select byte pick the target register, and the other five are ignored. A select value above 07h is still acknowledged. For example, 0Dh writes register 5.
- R4: A data byte replaces its target register in a single update after the eighth bit, and no other register changes.
- R5: In a write, select and data bytes alternate without limit until a stop condition.
- R6: Every read transfer returns status byte A (register 8) first, whatever an earlier read did.
- R7: When bit 7 of register 0 is 0, read bytes cycle A, B, C (registers 8, 9, 0Ah) and then start again at A.
- R8: When bit 7 of register 0 is 1, read bytes cycle A, B, C, register 7, register 6, and then start again at A.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until a new start.
- R10: A status byte is captured at the moment it is loaded for sending. A change on the status input while that byte is being shifted out does not alter it, and the change appears the next time that byte comes up in the cycle.
- R11: sda_oe is a pull-low enable only, and it changes only while SCL is low.
- R12: After reset all control registers read zero and SDA is released.
- R13: A repeated start during a transfer returns the slave to the device-address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| stat_a_i | input | 8 | Status byte A (register 8) |
| stat_b_i | input | 8 | Status byte B (register 9) |
| stat_c_i | input | 8 | Status byte C (register 0Ah) |
| ctrl_o | output | 64 | Control registers, register n in bits 8n+7 to 8n |

## Verification
The bench sends a register-select byte above 07h. A design that decoded all eight bits would either skip that write or refuse to acknowledge it. A foreign address followed by a valid-looking select/data pair shows whether the slave really stays deaf after a mismatch.

Reads are run in both list lengths and ended at different points in the cycle. This exposes a sequencer that resumes where the last read stopped, or one that wraps at the wrong length. A NACK placed just before a byte whose top bit is zero shows whether the slave wrongly drives that next bit. A status change in the middle of a byte catches a design that samples status live instead of at load time. A repeated start placed between a select byte and its data exposes a pair machine that does not reset its phase.

// File: rtl/scb_pkg.sv
package scb_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SEQ_MAX = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_REG,
    PH_DATA,
    PH_TX
  } phase_t;

  // read list position -> register number
  function automatic logic [3:0] seq_reg(input logic [2:0] idx);
    case (idx)
      3'd0:    seq_reg = 4'd8;
      3'd1:    seq_reg = 4'd9;
      3'd2:    seq_reg = 4'd10;
      3'd3:    seq_reg = 4'd7;
      default: seq_reg = 4'd6;
    endcase
  endfunction

  // next list position; short list wraps after the third status byte
  function automatic logic [2:0] seq_next(input logic [2:0] idx, input logic long_list);
    if (idx == 3'd2 && !long_list)
      seq_next = 3'd0;
    else if (idx >= 3'(SEQ_MAX))
      seq_next = 3'd0;
    else
      seq_next = idx + 3'd1;
  endfunction

endpackage

// File: rtl/scb_line_sync.sv
module scb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/scb_regbank.sv
module scb_regbank
  import scb_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 8,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [2:0]       rd_idx,
  input  logic [DW-1:0]    stat_a,
  input  logic [DW-1:0]    stat_b,
  input  logic [DW-1:0]    stat_c,
  output logic [DW-1:0]    rd_data,
  output logic [NREG*DW-1:0] ctrl_flat
);

  logic [DW-1:0] q [NREG];
  logic [3:0]    rd_num;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[g] <= '0;
      else if (wr_en && wr_addr == AW'(g))
        q[g] <= wr_data;
    end
    assign ctrl_flat[g*DW +: DW] = q[g];

    a_r4_whole_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(g)) |=> (ctrl_flat[g*DW +: DW] == $past(wr_data)));
  end

  assign rd_num = seq_reg(rd_idx);

  always_comb begin
    case (rd_num)
      4'd8:    rd_data = stat_a;
      4'd9:    rd_data = stat_b;
      4'd10:   rd_data = stat_c;
      default: rd_data = q[rd_num[AW-1:0]];
    endcase
  end

endmodule

// File: rtl/scb_ctrl_slave.sv
module scb_ctrl_slave
  import scb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h06,
  parameter int unsigned DW       = 8,
  parameter int unsigned NREG     = 8,
  localparam int unsigned AW      = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic [DW-1:0]        stat_a_i,
  input  logic [DW-1:0]        stat_b_i,
  input  logic [DW-1:0]        stat_c_i,
  output logic [NREG*DW-1:0]   ctrl_o
);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_chain;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain <= 2'b00;
    else        rst_chain <= {rst_chain[0], 1'b1};
  end
  assign rst_s_n = rst_chain[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  scb_line_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_s),
    .sda_lvl  (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  phase_t        phase, phase_d;
  logic [3:0]    cnt, cnt_d;
  logic          in_ack, ack_d;
  logic [DW-1:0] sh, sh_d;
  logic          oe, oe_d;
  logic          mack, mack_d;
  logic [2:0]    idx, idx_d, load_idx;
  logic [AW-1:0] waddr, waddr_d;
  logic          wr_en;
  logic [DW-1:0] rd_data;
  logic          long_list;

  assign long_list = ctrl_o[DW-1];
  assign load_idx  = (phase == PH_DEV) ? 3'd0 : seq_next(idx, long_list);

  scb_regbank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_en    (wr_en),
    .wr_addr  (waddr),
    .wr_data  (sh),
    .rd_idx   (load_idx),
    .stat_a   (stat_a_i),
    .stat_b   (stat_b_i),
    .stat_c   (stat_c_i),
    .rd_data  (rd_data),
    .ctrl_flat(ctrl_o)
  );

  always_comb begin
    phase_d = phase;
    cnt_d   = cnt;
    ack_d   = in_ack;
    sh_d    = sh;
    oe_d    = oe;
    mack_d  = mack;
    idx_d   = idx;
    waddr_d = waddr;
    wr_en   = 1'b0;
    if (start_det) begin
      phase_d = PH_DEV;
      cnt_d   = '0;
      ack_d   = 1'b0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      ack_d   = 1'b0;
      oe_d    = 1'b0;
    end else begin
      case (phase)
        PH_DEV, PH_REG, PH_DATA: begin
          if (!in_ack) begin
            if (scl_rise && cnt != 4'd8) begin
              sh_d  = {sh[DW-2:0], sda_s};
              cnt_d = cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (phase == PH_DEV && sh[7:1] != DEV_ADDR) begin
                phase_d = PH_IDLE;
              end else begin
                oe_d  = 1'b1;
                ack_d = 1'b1;
              end
              if (phase == PH_REG)  waddr_d = sh[AW-1:0];
              if (phase == PH_DATA) wr_en   = 1'b1;
            end
          end else if (scl_fall) begin
            ack_d = 1'b0;
            cnt_d = '0;
            oe_d  = 1'b0;
            case (phase)
              PH_DEV: begin
                if (sh[0]) begin
                  phase_d = PH_TX;
                  sh_d    = rd_data;
                  oe_d    = ~rd_data[DW-1];
                  cnt_d   = 4'd1;
                  idx_d   = load_idx;
                end else begin
                  phase_d = PH_REG;
                end
              end
              PH_REG:  phase_d = PH_DATA;
              default: phase_d = PH_REG;
            endcase
          end
        end
        PH_TX: begin
          if (!in_ack) begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                oe_d  = 1'b0;
                ack_d = 1'b1;
              end else begin
                sh_d  = {sh[DW-2:0], 1'b0};
                oe_d  = ~sh[DW-2];
                cnt_d = cnt + 4'd1;
              end
            end
          end else begin
            if (scl_rise) mack_d = ~sda_s;
            if (scl_fall) begin
              ack_d = 1'b0;
              if (mack) begin
                sh_d  = rd_data;
                oe_d  = ~rd_data[DW-1];
                cnt_d = 4'd1;
                idx_d = load_idx;
              end else begin
                phase_d = PH_IDLE;
                oe_d    = 1'b0;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      in_ack <= 1'b0;
      sh     <= '0;
      oe     <= 1'b0;
      mack   <= 1'b0;
      idx    <= '0;
      waddr  <= '0;
    end else begin
      phase  <= phase_d;
      cnt    <= cnt_d;
      in_ack <= ack_d;
      sh     <= sh_d;
      oe     <= oe_d;
      mack   <= mack_d;
      idx    <= idx_d;
      waddr  <= waddr_d;
    end
  end

  assign sda_oe = oe;

  a_r11_pull_when_scl_low: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(sda_oe) |-> !scl_s);

  a_r8_list_bound: assert property (@(posedge clk) disable iff (!rst_s_n)
    idx <= 3'(SEQ_MAX));

  a_r7_short_list_stays: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!long_list && idx <= 3'd2 && !wr_en) |=> (idx <= 3'd2));

  a_r9_release_after_nack: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase == PH_TX && in_ack && scl_fall && !mack && !start_det && !stop_det) |=> !sda_oe);

  a_r4_write_in_low_phase: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_en |-> !scl_s);

endmodule

// File: tb/scb_ctrl_slave_test.sv
`timescale 1ns/1ps
module scb_ctrl_slave_test;

  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m;
  logic        m_low;
  logic [7:0]  st_a, st_b, st_c;
  logic        sda_oe;
  logic [63:0] ctrl_o;
  wire         sda_bus = ~(m_low | sda_oe);

  int checks = 0;
  int errors = 0;
  logic [7:0] mreg [8];
  bit   cmp_en = 0;
  logic prev_oe = 1'b0;

  always #2 clk = ~clk;

  scb_ctrl_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .stat_a_i(st_a), .stat_b_i(st_b), .stat_c_i(st_c), .ctrl_o(ctrl_o)
  );

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = mreg[i];
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference compare of the register bank while the bus rests (R4 R12)
  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (ctrl_o !== model_flat()) begin
        errors++;
        $display("FAIL R4 ctrl actual=%0h expected=%0h", ctrl_o, model_flat());
      end
    end
  end

  // R11: the pull-low enable may move only while the bench holds SCL low
  always @(negedge clk) begin
    if (rst_n === 1'b1 && sda_oe !== prev_oe) begin
      checks++;
      if (scl_m !== 1'b0) begin
        errors++;
        $display("FAIL R11 sda_oe changed with scl=%0b expected scl=0", scl_m);
      end
    end
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    cmp_en = 0;
    m_low = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    m_low = 1'b0; tick(2*Q);
    cmp_en = 1;
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(Q);
      scl_m = 1'b1;  tick(2*Q);
      scl_m = 1'b0;  tick(Q);
    end
    m_low = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = (sda_bus == 1'b0);
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(output logic [7:0] b, input bit give_ack, input int flip_bit, input logic [7:0] flip_val);
    for (int i = 7; i >= 0; i--) begin
      m_low = 1'b0; tick(Q);
      if (i == flip_bit) st_a = flip_val;
      scl_m = 1'b1; tick(Q);
      b[i] = sda_bus;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    m_low = give_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    m_low = 1'b0;
  endtask

  task automatic write_pair(input logic [7:0] sel, input logic [7:0] dat, input string req);
    bit a;
    wr_byte(sel, a); chk(a, {req, " select ack"}, a, 1);
    wr_byte(dat, a); chk(a, {req, " data ack"}, a, 1);
    mreg[sel[2:0]] = dat;
  endtask

  task automatic read_run(input logic [7:0] exp [], input string req);
    bit a;
    logic [7:0] b;
    bus_start();
    wr_byte(8'h0D, a); chk(a, {req, " read address ack"}, a, 1);
    foreach (exp[k]) begin
      rd_byte(b, k != exp.size() - 1, -1, 8'h00);
      chk(b == exp[k], req, b, exp[k]);
    end
    bus_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    logic [7:0] e [];
    rst_n = 1'b0; scl_m = 1'b1; m_low = 1'b0;
    st_a = 8'h11; st_b = 8'h22; st_c = 8'h33;
    for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(ctrl_o == 64'h0, "R12 registers zero", ctrl_o, 0);
    chk(sda_oe == 1'b0, "R12 sda released", sda_oe, 0);
    cmp_en = 1;

    // R1 R2 R3 R5: several pairs in one transfer, one select above 07h
    bus_start();
    wr_byte(8'h0C, a); chk(a, "R1 address 06h write acked", a, 1);
    write_pair(8'h01, 8'h5A, "R2 R5");
    write_pair(8'h03, 8'hC3, "R5");
    write_pair(8'h0D, 8'h77, "R3 select 0Dh");
    bus_stop();
    chk(ctrl_o[47:40] == 8'h77, "R3 register 5", ctrl_o[47:40], 8'h77);
    chk(ctrl_o[15:8] == 8'h5A, "R4 register 1", ctrl_o[15:8], 8'h5A);

    // R1: foreign address, then an otherwise valid pair is ignored
    bus_start();
    wr_byte(8'h0E, a); chk(!a, "R1 foreign address not acked", a, 0);
    wr_byte(8'h02, a); chk(!a, "R1 select ignored", a, 0);
    wr_byte(8'h99, a); chk(!a, "R1 data ignored", a, 0);
    bus_stop();
    chk(ctrl_o[23:16] == 8'h00, "R1 register 2 unchanged", ctrl_o[23:16], 0);

    // R6 R7: short list
    e = '{8'h11, 8'h22, 8'h33, 8'h11, 8'h22, 8'h33, 8'h11, 8'h22};
    read_run(e, "R7 short cycle");
    e = '{8'h11, 8'h22};
    read_run(e, "R6 restart at A");

    // R10: status A changes in mid-byte
    bus_start();
    wr_byte(8'h0D, a); chk(a, "R10 read address ack", a, 1);
    rd_byte(b, 1, 4, 8'h44); chk(b == 8'h11, "R10 byte held during shift", b, 8'h11);
    rd_byte(b, 1, -1, 0);    chk(b == 8'h22, "R10 B", b, 8'h22);
    rd_byte(b, 1, -1, 0);    chk(b == 8'h33, "R10 C", b, 8'h33);
    rd_byte(b, 0, -1, 0);    chk(b == 8'h44, "R10 new value next time", b, 8'h44);
    bus_stop();

    // R9: NACK ahead of a byte whose top bit is 0
    bus_start();
    wr_byte(8'h0D, a);
    rd_byte(b, 0, -1, 0); chk(b == 8'h44, "R9 first byte", b, 8'h44);
    tick(Q);
    chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
    scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    chk(sda_oe == 1'b0, "R9 silent on further clocks", sda_oe, 0);
    bus_stop();

    // R8: long list
    bus_start();
    wr_byte(8'h0C, a);
    write_pair(8'h00, 8'h80, "R8 mode");
    write_pair(8'h07, 8'hA7, "R8");
    write_pair(8'h06, 8'hB6, "R8");
    bus_stop();
    e = '{8'h44, 8'h22, 8'h33, 8'hA7, 8'hB6, 8'h44, 8'h22, 8'h33, 8'hA7, 8'hB6, 8'h44};
    read_run(e, "R8 long cycle");

    // R13: repeated start between select and data, then into a read
    bus_start();
    wr_byte(8'h0C, a);
    wr_byte(8'h02, a); chk(a, "R13 select ack", a, 1);
    bus_start();
    wr_byte(8'h0C, a); chk(a, "R13 address after repeated start", a, 1);
    write_pair(8'h02, 8'h5C, "R13");
    bus_start();
    wr_byte(8'h0D, a); chk(a, "R13 read after repeated start", a, 1);
    rd_byte(b, 0, -1, 0); chk(b == 8'h44, "R13 R6 read opens at A", b, 8'h44);
    bus_stop();
    chk(ctrl_o[23:16] == 8'h5C, "R13 register 2", ctrl_o[23:16], 8'h5C);

    tick(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule